// File: doc/BRIEF.md
# Dual-Edge Pad Capture with Half-Rate Gearbox

This block brings a group of single-bit input pads into the core. In its main configuration every pad is sampled on both edges of a fast clock, and each pair of samples is then regrouped onto a clock running at half that rate. The core therefore sees four bits per lane on every slow-clock cycle, with a fixed and documented bit order. The fast and slow clocks are phase-aligned: every second rising edge of the fast clock coincides with a rising edge of the slow clock.

Elaboration parameters set the lane count (1 to 128) and the register mode. The modes are a combinational bypass, a single rising-edge register, and dual-edge capture. Dual-edge capture can either feed the half-rate gearbox or present its two bits per lane directly on the fast clock. An active-low asynchronous clear can be included, and so can a pair of synchronous controls, clear and set. The synchronous controls act only on registers, so they have no effect in bypass mode.

Top module: `ddrx_input_path`

## Requirements
- R1: With the asynchronous clear enabled and in any register mode, `dout` is all zeros while `aclr_n` is low, from the moment it falls and without any clock edge.
- R2: In dual-edge mode each pad is sampled at both the rising edge and the falling edge of `clk_fr`. Both samples reach `dout`.
- R3: Lane i occupies `dout[4i+3:4i]`. In half-rate mode bit 0 is the rising-edge sample of the earlier fast cycle, bit 1 is the falling-edge sample of that cycle, bit 2 is the rising-edge sample of the later cycle and bit 3 is the falling-edge sample of the later cycle.
- R4: Number the rising edges of `clk_fr` as n. The half-rate word loaded at the `clk_hr` edge that coincides with fast edge n holds the samples of fast cycles n-3 (bits 1:0) and n-2 (bits 3:2). It then holds until the next `clk_hr` edge.
- R5: In dual-edge full-rate mode, after fast rising edge n each lane shows {falling, rising} sample of cycle n-1 in bits 1:0, and bits 3:2 read zero.
- R6: In simple mode, bit 0 of each lane equals the pad value sampled at the latest `clk_fr` rising edge, and bits 3:1 read zero.
- R7: In bypass mode, bit 0 of each lane follows the pad without a clock and bits 3:1 read zero. `aclr_n`, `sclr` and `sset` have no effect.
- R8: `sclr` high at an output-clock edge makes every register bit of `dout` zero from that edge onward.
- R9: `sset` high (with `sclr` low) sets every register bit of a lane. The lane then reads 4'b1111 in half-rate mode, 4'b0011 in dual-edge full-rate mode and 4'b0001 in simple mode.
- R10: When `sclr` and `sset` are high together, the clear wins and `dout` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fr | input | 1 | Full-rate capture clock |
| clk_hr | input | 1 | Half-rate clock, rising edge aligned with every second `clk_fr` rising edge |
| aclr_n | input | 1 | Asynchronous clear, active low |
| sclr | input | 1 | Synchronous clear, active high, wins over `sset` |
| sset | input | 1 | Synchronous set, active high |
| pad | input | LANES | Pad input bit per lane |
| dout | output | 4*LANES | Four bits per lane toward the core |

## Verification
The synchronous clear and the synchronous set can arrive in the same cycle. The bench holds both high together for several fast cycles, across at least two slow-clock edges. It then expects all-zero words from the half-rate, full-rate and simple instances, while the bypass instance keeps following the pad. A second collision is the asynchronous clear falling in the middle of a fast cycle while data keeps streaming. The outputs are sampled one nanosecond later, before any clock edge, and must already read zero.

// File: rtl/ddrx_pkg.sv
package ddrx_pkg;

    typedef enum logic [1:0] {
        MODE_BYPASS = 2'd0,
        MODE_SIMPLE = 2'd1,
        MODE_DDR    = 2'd2
    } reg_mode_e;

    localparam int LANE_BITS = 4;

    // Two samples taken within one full-rate cycle
    typedef struct packed {
        logic fall;
        logic rise;
    } edge_pair_t;

    // Four bits of one lane in one half-rate cycle
    typedef struct packed {
        edge_pair_t later;
        edge_pair_t earlier;
    } lane_word_t;

    // Clear beats set, set beats data
    function automatic logic gate_bit(input logic d, input logic clr, input logic set);
        if (clr) return 1'b0;
        if (set) return 1'b1;
        return d;
    endfunction

    function automatic edge_pair_t gate_pair(input edge_pair_t d, input logic clr, input logic set);
        edge_pair_t r;
        r.fall = gate_bit(d.fall, clr, set);
        r.rise = gate_bit(d.rise, clr, set);
        return r;
    endfunction

    function automatic lane_word_t gate_word(input lane_word_t d, input logic clr, input logic set);
        lane_word_t r;
        r.later   = gate_pair(d.later, clr, set);
        r.earlier = gate_pair(d.earlier, clr, set);
        return r;
    endfunction

    // Per-lane value produced by the synchronous set in each mode
    function automatic logic [LANE_BITS-1:0] set_pattern(input reg_mode_e m, input bit half);
        if (m == MODE_DDR && half) return 4'b1111;
        if (m == MODE_DDR)         return 4'b0011;
        if (m == MODE_SIMPLE)      return 4'b0001;
        return 4'b0000;
    endfunction

endpackage

// File: rtl/ddrx_edge_capture.sv
module ddrx_edge_capture
    import ddrx_pkg::*;
#(
    parameter int LANES     = 4,
    parameter bit DUAL_EDGE = 1'b1
) (
    input  logic                   clk_fr,
    input  logic                   clr_n,
    input  logic                   s_clr,
    input  logic                   s_set,
    input  logic [LANES-1:0]       pad,
    output edge_pair_t [LANES-1:0] cap_q
);

    logic [LANES-1:0] rise_r;

    always_ff @(posedge clk_fr or negedge clr_n) begin
        if (!clr_n) begin
            rise_r <= '0;
        end else begin
            for (int i = 0; i < LANES; i++) begin
                rise_r[i] <= gate_bit(pad[i], s_clr, s_set);
            end
        end
    end

    generate
        if (DUAL_EDGE) begin : g_dual
            logic [LANES-1:0]       fall_r;
            edge_pair_t [LANES-1:0] pair_r;

            always_ff @(negedge clk_fr or negedge clr_n) begin
                if (!clr_n) begin
                    fall_r <= '0;
                end else begin
                    for (int i = 0; i < LANES; i++) begin
                        fall_r[i] <= gate_bit(pad[i], s_clr, s_set);
                    end
                end
            end

            // Re-time the finished pair of the previous cycle onto the rising edge
            always_ff @(posedge clk_fr or negedge clr_n) begin
                if (!clr_n) begin
                    pair_r <= '0;
                end else begin
                    for (int i = 0; i < LANES; i++) begin
                        pair_r[i] <= gate_pair(edge_pair_t'{fall: fall_r[i], rise: rise_r[i]},
                                               s_clr, s_set);
                    end
                end
            end

            assign cap_q = pair_r;
        end else begin : g_single
            for (genvar i = 0; i < LANES; i++) begin : g_lane
                assign cap_q[i] = edge_pair_t'{fall: 1'b0, rise: rise_r[i]};
            end
        end
    endgenerate

endmodule

// File: rtl/ddrx_rate_halver.sv
module ddrx_rate_halver
    import ddrx_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                   clk_fr,
    input  logic                   clk_hr,
    input  logic                   clr_n,
    input  logic                   s_clr,
    input  logic                   s_set,
    input  edge_pair_t [LANES-1:0] pair_in,
    output lane_word_t [LANES-1:0] word_q
);

    edge_pair_t [LANES-1:0] hold_r;
    lane_word_t [LANES-1:0] word_r;

    // Keeps the pair of the earlier full-rate cycle
    always_ff @(posedge clk_fr or negedge clr_n) begin
        if (!clr_n) begin
            hold_r <= '0;
        end else begin
            for (int i = 0; i < LANES; i++) begin
                hold_r[i] <= gate_pair(pair_in[i], s_clr, s_set);
            end
        end
    end

    // Slow edge coincides with a fast edge; both sources are read before they update
    always_ff @(posedge clk_hr or negedge clr_n) begin
        if (!clr_n) begin
            word_r <= '0;
        end else begin
            for (int i = 0; i < LANES; i++) begin
                word_r[i] <= gate_word(lane_word_t'{later: pair_in[i], earlier: hold_r[i]},
                                       s_clr, s_set);
            end
        end
    end

    assign word_q = word_r;

endmodule

// File: rtl/ddrx_input_path.sv
module ddrx_input_path
    import ddrx_pkg::*;
#(
    parameter int        LANES        = 4,
    parameter reg_mode_e MODE         = MODE_DDR,
    parameter bit        HALF_RATE    = 1'b1,
    parameter bit        USE_ACLR     = 1'b1,
    parameter bit        USE_SYNC_CTL = 1'b1
) (
    input  logic                       clk_fr,
    input  logic                       clk_hr,
    input  logic                       aclr_n,
    input  logic                       sclr,
    input  logic                       sset,
    input  logic [LANES-1:0]           pad,
    output logic [LANES*LANE_BITS-1:0] dout
);

    localparam int  OUT_W    = LANES * LANE_BITS;
    localparam bit  USE_GEAR = (MODE == MODE_DDR) && HALF_RATE;

    logic clr_n;
    logic s_clr;
    logic s_set;

    assign clr_n = USE_ACLR     ? aclr_n : 1'b1;
    assign s_clr = USE_SYNC_CTL ? sclr   : 1'b0;
    assign s_set = USE_SYNC_CTL ? sset   : 1'b0;

    lane_word_t [LANES-1:0] lane_out;

    generate
        if (MODE == MODE_BYPASS) begin : g_bypass
            for (genvar i = 0; i < LANES; i++) begin : g_lane
                assign lane_out[i] = lane_word_t'{
                    later:   edge_pair_t'{fall: 1'b0, rise: 1'b0},
                    earlier: edge_pair_t'{fall: 1'b0, rise: pad[i]}
                };
            end
        end else begin : g_reg
            edge_pair_t [LANES-1:0] cap;

            ddrx_edge_capture #(
                .LANES     (LANES),
                .DUAL_EDGE (MODE == MODE_DDR)
            ) u_capture (
                .clk_fr (clk_fr),
                .clr_n  (clr_n),
                .s_clr  (s_clr),
                .s_set  (s_set),
                .pad    (pad),
                .cap_q  (cap)
            );

            if (USE_GEAR) begin : g_half
                ddrx_rate_halver #(
                    .LANES (LANES)
                ) u_halver (
                    .clk_fr  (clk_fr),
                    .clk_hr  (clk_hr),
                    .clr_n   (clr_n),
                    .s_clr   (s_clr),
                    .s_set   (s_set),
                    .pair_in (cap),
                    .word_q  (lane_out)
                );
            end else begin : g_full
                for (genvar i = 0; i < LANES; i++) begin : g_lane
                    assign lane_out[i] = lane_word_t'{
                        later:   edge_pair_t'{fall: 1'b0, rise: 1'b0},
                        earlier: cap[i]
                    };
                end
            end
        end
    endgenerate

    assign dout = OUT_W'(lane_out);

endmodule

// File: rtl/ddrx_input_path_chk.sv
module ddrx_input_path_chk
    import ddrx_pkg::*;
#(
    parameter int        LANES        = 4,
    parameter reg_mode_e MODE         = MODE_DDR,
    parameter bit        HALF_RATE    = 1'b1,
    parameter bit        USE_ACLR     = 1'b1,
    parameter bit        USE_SYNC_CTL = 1'b1
) (
    input logic                       clk_fr,
    input logic                       clk_hr,
    input logic                       aclr_n,
    input logic                       sclr,
    input logic                       sset,
    input logic [LANES-1:0]           pad,
    input logic [LANES*LANE_BITS-1:0] dout
);

    localparam int                   OUT_W    = LANES * LANE_BITS;
    localparam logic [LANE_BITS-1:0] SET_LANE = set_pattern(MODE, HALF_RATE);
    localparam logic [OUT_W-1:0]     SET_WORD = {LANES{SET_LANE}};

    logic out_clk;
    assign out_clk = (MODE == MODE_DDR && HALF_RATE) ? clk_hr : clk_fr;

    generate
        if (USE_ACLR && MODE != MODE_BYPASS) begin : g_aclr
            always @(negedge clk_fr) begin
                if (!aclr_n) begin
                    assert_async_clear_R1: assert (dout == '0)
                        else $error("R1: dout %h while clear held", dout);
                end
            end
        end

        if (USE_SYNC_CTL && MODE != MODE_BYPASS) begin : g_sync
            assert_sync_clear_R8: assert property (@(posedge out_clk) disable iff (!aclr_n)
                sclr |=> (dout == '0));

            assert_sync_set_R9: assert property (@(posedge out_clk) disable iff (!aclr_n)
                (sset && !sclr) |=> (dout == SET_WORD));

            assert_clear_priority_R10: assert property (@(posedge out_clk) disable iff (!aclr_n)
                (sset && sclr) |=> (dout == '0));
        end

        if (MODE == MODE_SIMPLE) begin : g_simple
            logic [LANES-1:0] bit0;
            for (genvar i = 0; i < LANES; i++) begin : g_lane
                assign bit0[i] = dout[i*LANE_BITS];
            end
            assert_simple_capture_R6: assert property (@(posedge clk_fr) disable iff (!aclr_n)
                (!sclr && !sset) |=> (bit0 == $past(pad)));
        end
    endgenerate

endmodule

bind ddrx_input_path ddrx_input_path_chk #(
    .LANES        (LANES),
    .MODE         (MODE),
    .HALF_RATE    (HALF_RATE),
    .USE_ACLR     (USE_ACLR),
    .USE_SYNC_CTL (USE_SYNC_CTL)
) u_chk (
    .clk_fr (clk_fr),
    .clk_hr (clk_hr),
    .aclr_n (aclr_n),
    .sclr   (sclr),
    .sset   (sset),
    .pad    (pad),
    .dout   (dout)
);

// File: tb/test_ddrx_input_path.sv
module test_ddrx_input_path;
    import ddrx_pkg::*;

    localparam int L = 3;
    localparam int W = L * 4;

    logic         clk_fr;
    logic         clk_hr;
    logic         aclr_n;
    logic         sclr;
    logic         sset;
    logic [L-1:0] pad;
    logic [W-1:0] dout_hr, dout_fr, dout_sr, dout_bp;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    ddrx_input_path #(.LANES(L), .MODE(MODE_DDR), .HALF_RATE(1'b1)) i_ddrx_input_path (
        .clk_fr(clk_fr), .clk_hr(clk_hr), .aclr_n(aclr_n), .sclr(sclr), .sset(sset),
        .pad(pad), .dout(dout_hr));

    ddrx_input_path #(.LANES(L), .MODE(MODE_DDR), .HALF_RATE(1'b0)) i_ddrx_input_path_fr (
        .clk_fr(clk_fr), .clk_hr(clk_hr), .aclr_n(aclr_n), .sclr(sclr), .sset(sset),
        .pad(pad), .dout(dout_fr));

    ddrx_input_path #(.LANES(L), .MODE(MODE_SIMPLE), .HALF_RATE(1'b0)) i_ddrx_input_path_sr (
        .clk_fr(clk_fr), .clk_hr(clk_hr), .aclr_n(aclr_n), .sclr(sclr), .sset(sset),
        .pad(pad), .dout(dout_sr));

    ddrx_input_path #(.LANES(L), .MODE(MODE_BYPASS), .HALF_RATE(1'b0)) i_ddrx_input_path_bp (
        .clk_fr(clk_fr), .clk_hr(clk_hr), .aclr_n(aclr_n), .sclr(sclr), .sset(sset),
        .pad(pad), .dout(dout_bp));

    // 50 MHz fast clock; slow clock toggles on every fast rising edge
    initial begin
        clk_fr = 1'b0;
        clk_hr = 1'b0;
        forever begin
            #10;
            clk_fr = 1'b1;
            clk_hr = ~clk_hr;
            #10;
            clk_fr = 1'b0;
        end
    end

    // Pad bit of fast cycle n, edge e (0 rising, 1 falling), lane l; pattern changes every 50 cycles
    function automatic logic pbit(input int n, input int e, input int l);
        int unsigned x;
        case ((n / 50) % 4)
            0: begin
                x = int'(n * 2 + e) * 32'd2654435761 + l * 32'd40503;
                x = x ^ (x >> 15);
                return x[7];
            end
            1: return (e == 0);
            2: return logic'(((n >> 1) ^ l) & 1);
            default: begin
                x = int'(n * 3 + e * 5 + l * 11) * 32'h9E3779B1;
                return x[23];
            end
        endcase
    endfunction

    function automatic logic [W-1:0] exp_hr(input int m);
        logic [W-1:0] r;
        for (int l = 0; l < L; l++) begin
            r[l*4 +: 4] = {pbit(m-2, 1, l), pbit(m-2, 0, l), pbit(m-3, 1, l), pbit(m-3, 0, l)};
        end
        return r;
    endfunction

    function automatic logic [W-1:0] exp_fr(input int n);
        logic [W-1:0] r;
        for (int l = 0; l < L; l++) begin
            r[l*4 +: 4] = {2'b00, pbit(n-1, 1, l), pbit(n-1, 0, l)};
        end
        return r;
    endfunction

    function automatic logic [W-1:0] exp_rise(input int n);
        logic [W-1:0] r;
        for (int l = 0; l < L; l++) begin
            r[l*4 +: 4] = {3'b000, pbit(n, 0, l)};
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp,
                         input int n);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, n, act, exp);
        end
    endtask

    task automatic drive_rise(input int n);
        for (int l = 0; l < L; l++) pad[l] = pbit(n, 0, l);
    endtask

    task automatic drive_fall(input int n);
        for (int l = 0; l < L; l++) pad[l] = pbit(n, 1, l);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not end, actual hung expected finished");
        finish_run();
    end

    initial begin
        int  disturb;
        bit  quiet;
        int  m;
        aclr_n  = 1'b0;
        sclr    = 1'b0;
        sset    = 1'b0;
        disturb = 3;
        quiet   = 1'b0;
        drive_rise(0);

        for (int n = 0; n < 400; n++) begin
            @(posedge clk_fr);
            #2;
            m = (clk_hr == 1'b1) ? n : n - 1;

            if (!aclr_n) begin
                // R1 reset state; R7 bypass ignores the clear
                check("R1 half-rate cleared", dout_hr, '0, n);
                check("R1 full-rate cleared", dout_fr, '0, n);
                check("R1 simple cleared",    dout_sr, '0, n);
                check("R7 bypass under clear", dout_bp, exp_rise(n), n);
            end else if (n >= 202 && n <= 206) begin
                check("R8 half-rate sclr", dout_hr, '0, n);
                check("R8 full-rate sclr", dout_fr, '0, n);
                check("R8 simple sclr",    dout_sr, '0, n);
                check("R7 bypass ignores sclr", dout_bp, exp_rise(n), n);
            end else if (n >= 232 && n <= 236) begin
                check("R9 half-rate sset", dout_hr, {L{4'b1111}}, n);
                check("R9 full-rate sset", dout_fr, {L{4'b0011}}, n);
                check("R9 simple sset",    dout_sr, {L{4'b0001}}, n);
                check("R7 bypass ignores sset", dout_bp, exp_rise(n), n);
            end else if (n >= 262 && n <= 266) begin
                check("R10 half-rate clear wins", dout_hr, '0, n);
                check("R10 full-rate clear wins", dout_fr, '0, n);
                check("R10 simple clear wins",    dout_sr, '0, n);
                check("R7 bypass ignores both",   dout_bp, exp_rise(n), n);
            end else if (!quiet && (n - disturb) >= 5) begin
                check("R2 R3 R4 half-rate word", dout_hr, exp_hr(m), n);
                check("R2 R5 full-rate pair",    dout_fr, exp_fr(n), n);
                check("R6 simple register",      dout_sr, exp_rise(n), n);
                check("R7 bypass follows pad",   dout_bp, exp_rise(n), n);
            end

            #3;
            case (n)
                3:   begin aclr_n = 1'b1; disturb = 3; end
                200: begin sclr = 1'b1; quiet = 1'b1; end
                206: begin sclr = 1'b0; disturb = 207; quiet = 1'b0; end
                230: begin sset = 1'b1; quiet = 1'b1; end
                236: begin sset = 1'b0; disturb = 237; quiet = 1'b0; end
                260: begin sclr = 1'b1; sset = 1'b1; quiet = 1'b1; end
                266: begin sclr = 1'b0; sset = 1'b0; disturb = 267; quiet = 1'b0; end
                300: begin
                    aclr_n = 1'b0;
                    quiet  = 1'b1;
                    #1;
                    // R1: cleared mid-cycle with no clock edge in between
                    check("R1 half-rate async", dout_hr, '0, n);
                    check("R1 full-rate async", dout_fr, '0, n);
                    check("R1 simple async",    dout_sr, '0, n);
                    check("R7 bypass ignores aclr", dout_bp, exp_rise(n), n);
                end
                303: begin aclr_n = 1'b1; disturb = 303; quiet = 1'b0; end
                default: ;
            endcase
            drive_fall(n);

            @(negedge clk_fr);
            #5;
            drive_rise(n + 1);
        end

        finish_run();
    end

endmodule